// File: doc/BRIEF.md
# Dead-Band Phase-Frequency Detector

This block compares two slow square-wave inputs, a reference and a feedback signal, by oversampling both with a fast system clock. A rising edge on the reference raises the `up` output. A rising edge on the feedback raises the `dn` output. Once both outputs are high, a timed clear path holds them together for a programmed number of clock cycles and then drops them in the same cycle. As a result, an overlap pulse can never be narrower than the programmed width. This holds even when the inputs are perfectly aligned, where both outputs emit equal pulses of exactly that width.

After each clear, a programmed recovery window follows in which rising edges on either input are discarded, not stored for later. The clear width plus the recovery window form the detector's dead time. During that time the net up-minus-down indication is zero. The dead time shrinks the detectable phase error below one full input period by a factor of one minus the dead time over the period; for example, 8.5 ns of dead time at 25 MHz leaves roughly 0.79 of a cycle.

Beside `up` and `dn`, the block reports a 2-bit state code and a signed 2-bit up-minus-down value, all registered. It feeds a charge pump or a digital loop filter.

Top module: `pfd_deadband`

## Requirements
- R1: A synchronous active-high `rst` sets every output to 0 and clears the timers, the synchronizers and the edge history. An input held high through reset is therefore treated as a fresh rising edge after release, and `up` rises on the third rising clock edge after `rst` falls.
- R2: A rising edge on `ref_in` sets `up`. Counting from the clock edge that first samples the new level, `up` shows the change after the third rising clock edge: two synchronizer stages, then the output register.
- R3: A rising edge on `fb_in` sets `dn` with the same latency as R2.
- R4: Further rising edges on an input whose output is already high leave all outputs unchanged.
- R5: Once `up` and `dn` are both high, both stay high for exactly RESET_CYC clock cycles and then fall together in the same cycle.
- R6: Rising edges detected on both inputs in the same sample raise `up` and `dn` in the same cycle. The pair then follows R5.
- R7: Take the cycle in which the outputs fall as cycle 0. Rising edges that reach the edge detector during the hold, or during the RECOVER_CYC decision cycles that follow cycle 0, are dropped and never show up later. An edge whose decision falls on the first cycle after that window is accepted. With the bench values (RESET_CYC=4, RECOVER_CYC=3), an input driven high 4 cycles after the first both-high sample is dropped, and one driven high 5 cycles after it is accepted.
- R8: `state_code` is 0 for neither output high, 1 for `up` only, 2 for `dn` only, and 3 for both high. `up_minus_dn` is two's complement: 2'b01 for `up` only, 2'b11 for `dn` only, and 2'b00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference input |
| fb_in | input | 1 | Asynchronous feedback input |
| up | output | 1 | Reference-leads pulse |
| dn | output | 1 | Feedback-leads pulse |
| state_code | output | 2 | Detector state, {dn, up} encoding |
| up_minus_dn | output | 2 | Signed net output |

## Verification
The assertions check the following properties on every cycle:
- The overlap pulse is never shorter and never longer than RESET_CYC.
- An output only falls while the other output is also high.
- The state code and the signed difference always agree with `up` and `dn`.
- No output rises again sooner than the recovery window allows after a clear.

Other behaviour can only be shown by the bench's scenarios:
- Whether a given edge is accepted or dropped depends on its exact arrival cycle relative to the clear.
- The three-cycle input latency.
- The handling of an input held high through reset.
- The fact that a dropped edge is not queued.

The bench places stimulus on precise cycles to cover each of these.

// File: rtl/pfd_deadband_pkg.sv
package pfd_deadband_pkg;

  typedef enum logic [1:0] {
    PH_ARMED   = 2'd0,
    PH_HOLD    = 2'd1,
    PH_RECOVER = 2'd2
  } pfd_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_DN   = 2'd2,
    ST_BOTH = 2'd3
  } pfd_state_e;

endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/pfd_dwell_timer.sv
module pfd_dwell_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pfd_phase_ctrl.sv
module pfd_phase_ctrl
  import pfd_deadband_pkg::*;
#(
  parameter int RESET_CYC   = 4,
  parameter int RECOVER_CYC = 3,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic             fb_rise,
  input  logic             up_q,
  input  logic             dn_q,
  input  logic             tmr_zero,
  output logic             nxt_up,
  output logic             nxt_dn,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(RESET_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD  =
    CNT_W'((RECOVER_CYC > 0) ? RECOVER_CYC - 1 : 0);
  localparam bit HAS_RECOVER = (RECOVER_CYC > 0);

  pfd_phase_e phase_q, phase_d;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_ARMED;
    else     phase_q <= phase_d;
  end

  always_comb begin
    nxt_up   = up_q;
    nxt_dn   = dn_q;
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (phase_q)
      PH_ARMED: begin
        nxt_up = up_q | ref_rise;
        nxt_dn = dn_q | fb_rise;
        if (nxt_up && nxt_dn) begin
          phase_d  = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LOAD;
        end
      end
      PH_HOLD: begin
        if (tmr_zero) begin
          nxt_up = 1'b0;
          nxt_dn = 1'b0;
          if (HAS_RECOVER) begin
            phase_d  = PH_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = REC_LOAD;
          end else begin
            phase_d = PH_ARMED;
          end
        end
      end
      PH_RECOVER: begin
        if (tmr_zero) phase_d = PH_ARMED;
      end
      default: phase_d = PH_ARMED;
    endcase
  end
endmodule

// File: rtl/pfd_out_reg.sv
module pfd_out_reg
  import pfd_deadband_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       nxt_up,
  input  logic       nxt_dn,
  output logic       up,
  output logic       dn,
  output logic [1:0] state_code,
  output logic [1:0] up_minus_dn
);
  pfd_state_e st_d;
  logic [1:0] diff_d;

  always_comb begin
    case ({nxt_dn, nxt_up})
      2'b01:   begin st_d = ST_UP;   diff_d = 2'b01; end
      2'b10:   begin st_d = ST_DN;   diff_d = 2'b11; end
      2'b11:   begin st_d = ST_BOTH; diff_d = 2'b00; end
      default: begin st_d = ST_IDLE; diff_d = 2'b00; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up          <= 1'b0;
      dn          <= 1'b0;
      state_code  <= ST_IDLE;
      up_minus_dn <= 2'b00;
    end else begin
      up          <= nxt_up;
      dn          <= nxt_dn;
      state_code  <= st_d;
      up_minus_dn <= diff_d;
    end
  end
endmodule

// File: rtl/pfd_deadband.sv
module pfd_deadband #(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_CYC   = 4,
  parameter int RECOVER_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic       fb_in,
  output logic       up,
  output logic       dn,
  output logic [1:0] state_code,
  output logic [1:0] up_minus_dn
);
  localparam int CNT_MAX = (RESET_CYC > RECOVER_CYC) ? RESET_CYC : RECOVER_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0]       raw_in;
  logic [1:0]       rise;
  logic             nxt_up, nxt_dn;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  assign raw_in = {fb_in, ref_in};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_in
      pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in[g]),
        .rise (rise[g])
      );
    end
  endgenerate

  pfd_dwell_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  pfd_phase_ctrl #(
    .RESET_CYC   (RESET_CYC),
    .RECOVER_CYC (RECOVER_CYC),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[0]),
    .fb_rise  (rise[1]),
    .up_q     (up),
    .dn_q     (dn),
    .tmr_zero (tmr_zero),
    .nxt_up   (nxt_up),
    .nxt_dn   (nxt_dn),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  pfd_out_reg u_out (
    .clk         (clk),
    .rst         (rst),
    .nxt_up      (nxt_up),
    .nxt_dn      (nxt_dn),
    .up          (up),
    .dn          (dn),
    .state_code  (state_code),
    .up_minus_dn (up_minus_dn)
  );
endmodule

// File: rtl/pfd_deadband_chk.sv
module pfd_deadband_chk #(
  parameter int RESET_CYC   = 4,
  parameter int RECOVER_CYC = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       up,
  input logic       dn,
  input logic [1:0] state_code,
  input logic [1:0] up_minus_dn
);
  localparam int RUN_W = $clog2(RESET_CYC + 2);
  localparam int GAP   = RECOVER_CYC + 1;
  localparam int LOW_W = $clog2(GAP + 2);

  logic             both;
  logic [RUN_W-1:0] run;
  logic             track;
  logic [LOW_W-1:0] low;
  logic [1:0]       diff_exp;

  assign both     = up & dn;
  assign diff_exp = (up && !dn) ? 2'b01 : ((dn && !up) ? 2'b11 : 2'b00);

  always_ff @(posedge clk) begin
    if (rst)                         run <= '0;
    else if (both && run <= RUN_W'(RESET_CYC)) run <= run + 1'b1;
    else if (!both)                  run <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      track <= 1'b0;
      low   <= '0;
    end else if (both) begin
      track <= 1'b1;
      low   <= '0;
    end else if (track) begin
      if (up || dn)                    track <= 1'b0;
      else if (low < LOW_W'(GAP + 1))  low   <= low + 1'b1;
    end
  end

  // R5
  hold_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!both && run != '0) |-> (run == RUN_W'(RESET_CYC)));

  // R5
  hold_max_chk: assert property (@(posedge clk) disable iff (rst)
    both |-> (run < RUN_W'(RESET_CYC)));

  // R5
  up_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(up) && !$past(rst)) |-> $past(dn));

  // R5
  dn_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dn) && !$past(rst)) |-> $past(up));

  // R8
  code_map_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == {dn, up}) && (up_minus_dn == diff_exp));

  // R7
  recover_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (track && low != '0 && (up || dn)) |-> (low >= LOW_W'(GAP)));
endmodule

bind pfd_deadband pfd_deadband_chk #(
  .RESET_CYC   (RESET_CYC),
  .RECOVER_CYC (RECOVER_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .up          (up),
  .dn          (dn),
  .state_code  (state_code),
  .up_minus_dn (up_minus_dn)
);

// File: tb/pfd_deadband_bench.sv
module pfd_deadband_bench;
  localparam int RST_W = 4;
  localparam int REC_W = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic       up, dn;
  logic [1:0] state_code, up_minus_dn;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pfd_deadband #(.SYNC_STAGES(2), .RESET_CYC(RST_W), .RECOVER_CYC(REC_W)) u_pfd_deadband (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .up(up), .dn(dn), .state_code(state_code), .up_minus_dn(up_minus_dn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(4);
  endtask

  task automatic measure_overlap(input string req);
    int w;
    w = 0;
    while (up && dn && w < 50) begin
      w++;
      tick(1);
    end
    chk({req, " overlap width"}, w, RST_W);
    chk({req, " both clear together"}, {up, dn}, 0);
  endtask

  // R1: reset state
  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    tick(2);
    chk("R1 up", up, 0);
    chk("R1 dn", dn, 0);
    chk("R1 state", state_code, 0);
    chk("R1 diff", up_minus_dn, 0);
    rst = 1'b0;
    tick(4);
  endtask

  // R2 R4 R5 R8: reference leads
  task automatic t_ref_lead();
    do_reset();
    ref_in = 1'b1;
    tick(2);
    chk("R2 latency not yet", up, 0);
    tick(1);
    chk("R2 up set", up, 1);
    chk("R8 state up", state_code, 1);
    chk("R8 diff +1", up_minus_dn, 1);
    ref_in = 1'b0;
    tick(3);
    ref_in = 1'b1;
    tick(2);
    ref_in = 1'b0;
    tick(4);
    chk("R4 second ref edge", {dn, up}, 1);
    chk("R4 state unchanged", state_code, 1);
    fb_in = 1'b1;
    tick(3);
    chk("R5 both high", {dn, up}, 3);
    chk("R8 state both", state_code, 3);
    chk("R8 diff zero", up_minus_dn, 0);
    fb_in = 1'b0;
    measure_overlap("R5 ref lead");
  endtask

  // R3 R8: feedback leads
  task automatic t_fb_lead();
    do_reset();
    fb_in = 1'b1;
    tick(2);
    chk("R3 latency not yet", dn, 0);
    tick(1);
    chk("R3 dn set", dn, 1);
    chk("R8 state dn", state_code, 2);
    chk("R8 diff -1", up_minus_dn, 3);
    fb_in = 1'b0;
    tick(5);
    ref_in = 1'b1;
    tick(3);
    ref_in = 1'b0;
    chk("R3 both high", {dn, up}, 3);
    measure_overlap("R5 fb lead");
  endtask

  // R6: aligned inputs
  task automatic t_aligned();
    do_reset();
    ref_in = 1'b1; fb_in = 1'b1;
    tick(2);
    chk("R6 none before", {dn, up}, 0);
    tick(1);
    chk("R6 both same cycle", {dn, up}, 3);
    chk("R6 state both", state_code, 3);
    ref_in = 1'b0; fb_in = 1'b0;
    measure_overlap("R6 aligned");
  endtask

  task automatic start_coincidence();
    do_reset();
    ref_in = 1'b1; fb_in = 1'b1;
    tick(3);
    ref_in = 1'b0; fb_in = 1'b0;
  endtask

  // R7: edge inside recovery dropped, not queued
  task automatic t_recover_drop();
    int seen;
    start_coincidence();
    tick(4);
    ref_in = 1'b1;
    tick(2);
    ref_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      if (up || dn) seen++;
      tick(1);
    end
    chk("R7 edge in recovery dropped", seen, 0);
  endtask

  // R7: first edge after recovery accepted
  task automatic t_recover_accept();
    start_coincidence();
    tick(5);
    ref_in = 1'b1;
    tick(2);
    chk("R7 not yet", up, 0);
    tick(1);
    chk("R7 edge after recovery accepted", up, 1);
    chk("R7 state up", state_code, 1);
    ref_in = 1'b0;
  endtask

  // R1: history cleared, mid-hold reset
  task automatic t_reset_history();
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b1; fb_in = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(2);
    chk("R1 held input not yet", up, 0);
    tick(1);
    chk("R1 held input seen as edge", up, 1);
    fb_in = 1'b1;
    tick(3);
    chk("R1 both before reset", {dn, up}, 3);
    rst = 1'b1;
    tick(1);
    chk("R1 mid-hold reset clears", {dn, up}, 0);
    chk("R1 mid-hold state", state_code, 0);
    rst = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    tick(4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    tick(2);
    t_reset_state();
    t_ref_lead();
    t_fb_lead();
    t_aligned();
    t_recover_drop();
    t_recover_accept();
    t_reset_history();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule